// File: doc/BRIEF.md
# Serial Character Link with Five-Way Parity

This block is a paired asynchronous serial transmitter and receiver that share one parity setting. The transmitter takes a parallel character and sends it as a start bit, the data bits least significant first, an optional parity bit and a stop bit. The receiver rebuilds characters from the incoming line, checks the parity bit against the active setting, and keeps a sticky parity-error flag. The flag is cleared only by a one-cycle clear strobe from the control side.

A 3-bit mode input selects among even, odd, forced-one (mark), forced-zero (space) and no parity. Each side copies the mode when a frame begins, so a change partway through a frame takes effect on the next one. A free-running divider makes a tick at sixteen times the bit rate. The transmitter holds each bit for sixteen ticks. The receiver confirms the start bit near its middle and then samples every later bit at its centre.

Top module: `uart_par_top`

## Requirements
- R1: The transmit line idles high. A frame is one low start bit, then DATA_W data bits least significant bit first, then the parity bit if enabled, then one high stop bit. Each bit lasts OVERSAMPLE*CLK_DIV clock cycles.
- R2: With mode 0 (even), the sent parity bit is the XOR of the data bits. The receiver flags an error when the sampled bit differs from it.
- R3: With mode 1 (odd), the sent parity bit is the inverse of the XOR of the data bits. The receiver flags an error when the sampled bit differs from it.
- R4: With mode 2 (mark), the parity bit is always sent as 1. The receiver flags an error when it samples 0.
- R5: With mode 3 (space), the parity bit is always sent as 0. The receiver flags an error when it samples 1.
- R6: With mode 4 (none; codes 5 to 7 behave the same), no parity bit is sent or expected. The stop bit follows the last data bit, and no parity error is ever flagged.
- R7: For each received frame, rx_valid is high for exactly one cycle. During that cycle rx_data holds the received character.
- R8: A parity error sets status_perr in the cycle after rx_valid. The flag stays set through later error-free frames. A clr_status pulse alone clears it in the following cycle.
- R9: If a parity error and clr_status occur in the same cycle, status_perr is set afterwards.
- R10: Each side samples the mode at the start of a frame. A mode change during a frame does not alter that frame's parity bit or its reception.
- R11: After reset, tx_line is high and tx_busy, rx_valid and status_perr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| par_mode | input | 3 | Parity mode: 0 even, 1 odd, 2 mark, 3 space, 4..7 none |
| tx_data | input | DATA_W | Character to send |
| tx_start | input | 1 | Start sending tx_data; taken only while tx_busy is low |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_line | output | 1 | Serial output |
| rx_line | input | 1 | Serial input, synchronised inside |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-cycle pulse when a character is received |
| clr_status | input | 1 | Clear strobe for the parity-error flag |
| status_perr | output | 1 | Sticky parity-error flag |

## Verification
The transmit line goes low on the first clock edge after tx_start is accepted. The bench therefore finds the falling edge and then samples half a bit in, and every full bit after that, which keeps each check at a bit centre whatever the start latency. rx_valid follows the stop-bit centre by a few cycles because of the two-stage input synchroniser. The bench waits for that pulse and reads rx_data in the same cycle. It reads status_perr exactly one cycle later, and for the clear strobe it also looks one cycle after the pulse. The same-cycle case drives clr_status in the cycle where rx_valid is seen, because the internal error pulse coincides with it.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

  typedef enum logic [2:0] {
    PM_EVEN  = 3'd0,
    PM_ODD   = 3'd1,
    PM_MARK  = 3'd2,
    PM_SPACE = 3'd3,
    PM_NONE  = 3'd4
  } par_mode_e;

  // Parity bit present in the frame for this mode
  function automatic logic par_used(input logic [2:0] mode);
    return (mode < 3'd4);
  endfunction

  // Parity bit value given the mode and the XOR of the data bits
  function automatic logic par_calc(input logic [2:0] mode, input logic ones_odd);
    logic p;
    case (mode)
      PM_EVEN:  p = ones_odd;
      PM_ODD:   p = ~ones_odd;
      PM_MARK:  p = 1'b1;
      default:  p = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/uart_par_baud.sv
module uart_par_baud #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_par_tx.sv
module uart_par_tx
  import uart_par_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic [2:0]    mode,
  output logic          line,
  output logic          busy
);
  localparam int FW  = DW + 3;
  localparam int BCW = $clog2(FW + 1);
  localparam int OCW = $clog2(OSR);

  logic           busy_q, busy_d;
  logic [FW-1:0]  sh_q, sh_d;
  logic [BCW-1:0] left_q, left_d;
  logic [OCW-1:0] os_q, os_d;
  logic [2:0]     mode_q, mode_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    left_d = left_q;
    os_d   = os_q;
    mode_d = mode_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        mode_d = mode;
        os_d   = '0;
        if (par_used(mode)) begin
          sh_d   = {1'b1, par_calc(mode, ^data), data, 1'b0};
          left_d = BCW'(FW);
        end else begin
          sh_d   = {2'b11, data, 1'b0};
          left_d = BCW'(FW - 1);
        end
      end
    end else if (tick) begin
      if (os_q == OCW'(OSR - 1)) begin
        os_d   = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - BCW'(1);
        if (left_q == BCW'(1)) busy_d = 1'b0;
      end else begin
        os_d = os_q + OCW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      os_q   <= '0;
      mode_q <= PM_NONE;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      os_q   <= os_d;
      mode_q <= mode_d;
    end
  end

  assign line = sh_q[0];
  assign busy = busy_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sh_q[0]);
  // R1
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !sh_q[0]);

endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx
  import uart_par_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [2:0]    mode,
  output logic [DW-1:0] data,
  output logic          valid,
  output logic          perr
);
  localparam int OCW = $clog2(OSR);
  localparam int IW  = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {RS_IDLE, RS_START, RS_DATA, RS_PAR, RS_STOP} rx_st_e;

  rx_st_e         st_q, st_d;
  logic [OCW-1:0] os_q, os_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [DW-1:0]  data_q, data_d;
  logic [2:0]     mode_q, mode_d;
  logic           pend_q, pend_d;
  logic           valid_q, valid_d;
  logic           perr_q, perr_d;
  logic           centre;

  assign centre = tick && (os_q == OCW'(OSR - 1));

  always_comb begin
    st_d    = st_q;
    os_d    = os_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    data_d  = data_q;
    mode_d  = mode_q;
    pend_d  = pend_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    if (tick && (st_q != RS_IDLE) && (st_q != RS_START)) begin
      os_d = centre ? '0 : os_q + OCW'(1);
    end
    case (st_q)
      RS_IDLE: begin
        if (tick && !line) begin
          st_d = RS_START;
          os_d = '0;
        end
      end
      RS_START: begin
        if (tick) begin
          if (os_q == OCW'(OSR / 2 - 1)) begin
            os_d = '0;
            if (!line) begin
              st_d   = RS_DATA;
              idx_d  = '0;
              mode_d = mode;
              pend_d = 1'b0;
            end else begin
              st_d = RS_IDLE;
            end
          end else begin
            os_d = os_q + OCW'(1);
          end
        end
      end
      RS_DATA: begin
        if (centre) begin
          sh_d = {line, sh_q[DW-1:1]};
          if (idx_q == IW'(DW - 1)) st_d = par_used(mode_q) ? RS_PAR : RS_STOP;
          else                      idx_d = idx_q + IW'(1);
        end
      end
      RS_PAR: begin
        if (centre) begin
          pend_d = (line != par_calc(mode_q, ^sh_q));
          st_d   = RS_STOP;
        end
      end
      RS_STOP: begin
        if (centre) begin
          valid_d = 1'b1;
          perr_d  = pend_q;
          data_d  = sh_q;
          st_d    = RS_IDLE;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RS_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      mode_q  <= PM_NONE;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      os_q    <= os_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign perr  = perr_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R6
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> par_used(mode_q));
  // R7
  perr_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> valid_q);

endmodule

// File: rtl/uart_par_top.sv
module uart_par_top #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int CLK_DIV    = 27,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        par_mode,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  output logic              tx_busy,
  output logic              tx_line,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              clr_status,
  output logic              status_perr
);
  logic [1:0]             rs_q;
  logic                   rst_i;
  logic [SYNC_STAGES-1:0] rxs_q;
  logic                   tick;
  logic                   rx_perr;
  logic                   status_q, status_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rxs_q <= '1;
    else        rxs_q <= {rxs_q[SYNC_STAGES-2:0], rx_line};
  end

  uart_par_baud #(.DIV(CLK_DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_i),
    .tick (tick)
  );

  uart_par_tx #(.DW(DATA_W), .OSR(OVERSAMPLE)) u_tx (
    .clk  (clk),
    .rst_n(rst_i),
    .tick (tick),
    .start(tx_start),
    .data (tx_data),
    .mode (par_mode),
    .line (tx_line),
    .busy (tx_busy)
  );

  uart_par_rx #(.DW(DATA_W), .OSR(OVERSAMPLE)) u_rx (
    .clk  (clk),
    .rst_n(rst_i),
    .tick (tick),
    .line (rxs_q[SYNC_STAGES-1]),
    .mode (par_mode),
    .data (rx_data),
    .valid(rx_valid),
    .perr (rx_perr)
  );

  always_comb begin
    status_d = rx_perr | (status_q & ~clr_status);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status_perr = status_q;

  // R9
  perr_sets_chk: assert property (@(posedge clk) disable iff (!rst_i)
    rx_perr |=> status_q);
  // R8
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (status_q && !clr_status) |=> status_q);
  // R8
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(status_q) |-> $past(clr_status));

endmodule

// File: tb/sim_uart_par_top.sv
module sim_uart_par_top;
  localparam int DW  = 8;
  localparam int OSR = 16;
  localparam int DIV = 1;
  localparam int BIT = OSR * DIV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    par_mode = 3'd0;
  logic [DW-1:0] tx_data = '0;
  logic          tx_start = 1'b0;
  logic          tx_busy, tx_line;
  logic          rx_line;
  logic [DW-1:0] rx_data;
  logic          rx_valid;
  logic          clr_status = 1'b0;
  logic          status_perr;
  logic          use_bb = 1'b0;
  logic          bb_line = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bit-bang capture state
  bit            seen, pv, clr_on_valid;
  logic [DW-1:0] got;
  logic          st_after;

  assign rx_line = use_bb ? bb_line : tx_line;

  always #4 clk = ~clk;

  uart_par_top #(.DATA_W(DW), .OVERSAMPLE(OSR), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .tx_data(tx_data),
    .tx_start(tx_start), .tx_busy(tx_busy), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .clr_status(clr_status), .status_perr(status_perr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [2:0] m, input logic [DW-1:0] d);
    case (m)
      3'd0:    return ^d;
      3'd1:    return ~^d;
      3'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string par_tag(input logic [2:0] m);
    case (m)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // Loopback frame; the mode switches to m2 after the first data bit (R10)
  task automatic frame_loop(input logic [DW-1:0] d, input logic [2:0] m, input logic [2:0] m2);
    logic [DW-1:0] bits;
    bit found;
    int wait_n;
    par_mode = m;
    tx_data  = d;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_n = 0;
    while (tx_line && wait_n < 4) begin @(negedge clk); wait_n++; end
    repeat (BIT/2) @(negedge clk);
    check(tx_line == 1'b0, "R1 start bit", tx_line, 0);
    for (int i = 0; i < DW; i++) begin
      repeat (BIT) @(negedge clk);
      bits[i] = tx_line;
      if (i == 0) par_mode = m2;
    end
    check(bits == d, "R1 data order", bits, d);
    if (m < 3'd4) begin
      repeat (BIT) @(negedge clk);
      check(tx_line == exp_par(m, d), (m != m2) ? "R10 tx parity" : par_tag(m),
            tx_line, exp_par(m, d));
    end
    repeat (BIT) @(negedge clk);
    check(tx_line == 1'b1, (m < 3'd4) ? "R1 stop bit" : "R6 stop after data", tx_line, 1);
    found = 1'b0;
    for (int c = 0; c < 2*BIT && !found; c++) begin
      if (rx_valid) found = 1'b1;
      else @(negedge clk);
    end
    check(found, "R7 rx_valid", found, 1);
    check(rx_data == d, (m != m2) ? "R10 rx data" : "R7 rx data", rx_data, d);
    @(negedge clk);
    check(rx_valid == 1'b0, "R7 one-cycle pulse", rx_valid, 0);
    check(status_perr == 1'b0, (m < 3'd4) ? par_tag(m) : "R6 no error", status_perr, 0);
    while (tx_busy) @(negedge clk);
    par_mode = m;
  endtask

  task automatic cyc;
    @(negedge clk);
    clr_status = 1'b0;
    if (pv) st_after = status_perr;
    pv = rx_valid;
    if (rx_valid) begin
      seen = 1'b1;
      got  = rx_data;
      if (clr_on_valid) clr_status = 1'b1;
    end
  endtask

  task automatic bb_bit(input logic v);
    bb_line = v;
    for (int c = 0; c < BIT; c++) cyc();
  endtask

  task automatic bb_frame(input logic [DW-1:0] d, input bit has_par, input logic p);
    seen = 1'b0; pv = 1'b0; st_after = 1'bx;
    use_bb = 1'b1;
    bb_bit(1'b0);
    for (int i = 0; i < DW; i++) bb_bit(d[i]);
    if (has_par) bb_bit(p);
    bb_bit(1'b1);
    bb_bit(1'b1);
    clr_on_valid = 1'b0;
  endtask

  task automatic clear_flag;
    @(negedge clk);
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    check(status_perr == 1'b0, "R8 clear", status_perr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11
    check(tx_line == 1'b1, "R11 tx_line", tx_line, 1);
    check(tx_busy == 1'b0, "R11 tx_busy", tx_busy, 0);
    check(rx_valid == 1'b0, "R11 rx_valid", rx_valid, 0);
    check(status_perr == 1'b0, "R11 status", status_perr, 0);

    // R2, R3: full sweep; R4, R5, R6: spread subset
    for (int d = 0; d < 256; d++) frame_loop(DW'(d), 3'd0, 3'd0);
    for (int d = 0; d < 256; d++) frame_loop(DW'(d), 3'd1, 3'd1);
    for (int k = 0; k < 16; k++) begin
      frame_loop(DW'(k * 17), 3'd2, 3'd2);
      frame_loop(DW'(k * 17), 3'd3, 3'd3);
      frame_loop(DW'(k * 17), 3'd4, 3'd4);
      frame_loop(DW'(k * 17), 3'd6, 3'd6);
    end
    // R10: mode changes mid-frame
    frame_loop(8'h41, 3'd0, 3'd4);
    frame_loop(8'h41, 3'd4, 3'd1);
    frame_loop(8'h41, 3'd2, 3'd3);

    // R4: mark, parity sampled 0 -> error
    par_mode = 3'd2;
    bb_frame(8'h41, 1'b1, 1'b0);
    check(seen && got == 8'h41, "R7 bb data", got, 8'h41);
    check(st_after == 1'b1, "R4 error on 0", st_after, 1);
    // R8: sticky through a good frame
    bb_frame(8'h41, 1'b1, 1'b1);
    check(st_after == 1'b1, "R8 sticky", st_after, 1);
    clear_flag();
    bb_frame(8'h41, 1'b1, 1'b1);
    check(st_after == 1'b0, "R4 no error on 1", st_after, 0);
    // R5
    par_mode = 3'd3;
    bb_frame(8'h41, 1'b1, 1'b1);
    check(st_after == 1'b1, "R5 error on 1", st_after, 1);
    clear_flag();
    bb_frame(8'h41, 1'b1, 1'b0);
    check(st_after == 1'b0, "R5 no error on 0", st_after, 0);
    // R2
    par_mode = 3'd0;
    bb_frame(8'h41, 1'b1, 1'b1);
    check(st_after == 1'b1, "R2 wrong even bit", st_after, 1);
    clear_flag();
    bb_frame(8'h07, 1'b1, 1'b1);
    check(st_after == 1'b0, "R2 right even bit", st_after, 0);
    // R3
    par_mode = 3'd1;
    bb_frame(8'h41, 1'b1, 1'b0);
    check(st_after == 1'b1, "R3 wrong odd bit", st_after, 1);
    clear_flag();
    bb_frame(8'h41, 1'b1, 1'b1);
    check(st_after == 1'b0, "R3 right odd bit", st_after, 0);
    // R6: no parity bit on the line, no error
    par_mode = 3'd4;
    bb_frame(8'hA5, 1'b0, 1'b0);
    check(seen && got == 8'hA5, "R6 data", got, 8'hA5);
    check(st_after == 1'b0, "R6 no error", st_after, 0);
    // R9: error and clear in the same cycle
    par_mode = 3'd2;
    clr_on_valid = 1'b1;
    bb_frame(8'h41, 1'b1, 1'b0);
    check(st_after == 1'b1, "R9 set wins", st_after, 1);
    clear_flag();
    use_bb = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule